// File: doc/BRIEF.md
# Slave Serial Configuration Loader

This block loads a bitstream into a downstream programmable device over a one-bit serial configuration link. After a start request it pulls the device's active-low program line down for a fixed number of system clocks, releases it, waits for the device's init line to go high, and then waits a settling delay. It then reads the bitstream from a byte-wide memory one byte at a time and shifts each byte out on a data line. A configuration clock is produced by dividing the system clock. The memory is read with one clock of latency. Every byte is passed through unchanged, padding and synchronisation words included, and the first memory read is done during the settling delay, so the configuration clock never stops between bytes.

Once the requested number of bytes has been sent, the loader drives the data line high and gives a set number of extra configuration clock pulses. During those pulses it looks for the device's done line. The run ends with success if done was seen and with error if it was not. A run also ends with error if init never rises within a timeout, or if init falls while data is being sent. The init and done inputs are asynchronous and pass through two-flop synchronisers. Timing parameters: `PROG_LOW_CYC`, `SETTLE_CYC`, `INIT_TIMEOUT_CYC`, `CCLK_HALF` (system clocks per half configuration clock) and `DONE_EXTRA` (tail pulses). Each must be at least 1, and `SETTLE_CYC` must be at least 2.

Top module: `cfg_serial_loader`

## Requirements
- R1: After reset, `prog_n` is 1, `cclk` is 0, `din` is 1, `mem_rd` is 0, and `busy`, `success` and `error` are all 0.
- R2: A `start` seen while idle drives `prog_n` low for exactly `PROG_LOW_CYC` clocks. `start` has no effect while `busy` is high.
- R3: The first rising edge of `cclk` arrives exactly 3 + `SETTLE_CYC` + `CCLK_HALF` clocks after the first clock edge at which `init_in` is high. This count is two synchroniser stages, one sequencer cycle, the settling delay and one half period.
- R4: If `init_in` stays low, the run ends with `error`, and `busy` is high for exactly `PROG_LOW_CYC` + `INIT_TIMEOUT_CYC` clocks from the start.
- R5: Every byte is sent most significant bit first, one bit per `cclk` rising edge. The `cclk` period is always 2·`CCLK_HALF` clocks, with no gap between bytes or before the tail pulses.
- R6: `din` changes only together with a falling edge of `cclk` or while `cclk` is low, and it is stable while `cclk` is high.
- R7: Exactly `byte_count` bytes are sent, read from addresses 0, 1, 2 … in order. A read returns `mem_data` one clock after `mem_rd` is sampled high, and stored values such as FF FF 55 99 AA 66 are sent as stored.
- R8: After the last data bit, exactly `DONE_EXTRA` more `cclk` pulses are given with `din` held at 1. The run then ends with `success` if `done_in` was seen high during streaming or the tail, and with `error` otherwise.
- R9: If `init_in` falls during streaming, sending stops, `cclk` returns low and the run ends with `error`.
- R10: A `byte_count` of 0 sends no data bits and gives only the `DONE_EXTRA` tail pulses.
- R11: `success` and `error` are never high together. Both clear on an accepted start and hold their value after `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a configuration run (accepted only while idle) |
| byte_count | input | CNT_W | Number of bitstream bytes, sampled at start |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | ADDR_W | Memory read address |
| mem_data | input | 8 | Memory read data, valid one clock after the strobe |
| prog_n | output | 1 | Active-low program request to the device |
| init_in | input | 1 | Device init indication (asynchronous) |
| cclk | output | 1 | Configuration clock |
| din | output | 1 | Serial configuration data |
| done_in | input | 1 | Device done indication (asynchronous) |
| busy | output | 1 | Run in progress |
| success | output | 1 | Last run completed with done seen |
| error | output | 1 | Last run failed |

## Verification
The program pulse, the time from init to the first `cclk` rise (3 + `SETTLE_CYC` + `CCLK_HALF` clocks) and the init-timeout length are fixed counts of system clocks. The bench measures each one by counting clock edges from its own stimulus edge and sampling one time unit after an edge or on the falling clock edge. Serial data is captured by a bench device model on each `cclk` rising edge. That model also checks that every `cclk` period is exactly 2·`CCLK_HALF` clocks, so the bench does not need to predict at which clock each bit appears. Status and tail-pulse totals are compared only after `busy` has fallen, and the expected values come from bench functions of the byte count and the parameters.

// File: rtl/cfg_loader_pkg.sv
`timescale 1ns/1ps
// Package: shared types and helpers for the serial configuration loader.
package cfg_loader_pkg;

    // Sequencer states of the loader.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG,
        ST_WAIT_INIT,
        ST_SETTLE,
        ST_STREAM,
        ST_TAIL
    } ld_state_e;

    // Larger of two unsigned values (used to size the shared delay timer).
    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/cfg_sync2.sv
`timescale 1ns/1ps
// cfg_sync2: two-flop synchroniser for asynchronous level inputs.
// Assumes inputs are slow levels; adds two clocks of latency, resets to 0.
module cfg_sync2 #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    // Two register stages per bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/cfg_delay_timer.sv
`timescale 1ns/1ps
// cfg_delay_timer: down-counter shared by the program, timeout and settle waits.
// Loading value V makes 'expired' high in the (V+1)-th cycle after the load.
module cfg_delay_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    // Load or count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - W'(1);
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/cfg_cclk_gen.sv
`timescale 1ns/1ps
// cfg_cclk_gen: divides the system clock into the configuration clock.
// Each phase lasts HALF system clocks; the clock starts low when enabled and
// is forced low at once when disabled. rise/fall flag the edge about to occur.
module cfg_cclk_gen #(
    parameter int HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic cclk,
    output logic rise_evt,
    output logic fall_evt
);
    localparam int HC_W = $clog2(HALF + 1);

    logic [HC_W-1:0] hc_q;
    logic            term;

    assign term     = en && (hc_q == HC_W'(HALF - 1));
    assign rise_evt = term && !cclk;
    assign fall_evt = term && cclk;

    // Half-period counter and clock toggle.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            hc_q <= '0;
            cclk <= 1'b0;
        end else if (term) begin
            hc_q <= '0;
            cclk <= ~cclk;
        end else begin
            hc_q <= hc_q + HC_W'(1);
        end
    end
endmodule

// File: rtl/cfg_byte_fetch.sv
`timescale 1ns/1ps
// cfg_byte_fetch: issues one-byte reads at consecutive addresses and holds the
// returned byte until taken. Assumes memory data is valid one clock after the
// strobe is sampled, and that a take never meets a capture in the same cycle.
module cfg_byte_fetch #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              req,
    input  logic              take,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_data,
    output logic [7:0]        buf_byte,
    output logic              buf_valid
);
    logic [ADDR_W-1:0] next_q;
    logic              pend_q;

    // Strobe, address sequencing and capture of the returned byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_rd    <= 1'b0;
            mem_addr  <= '0;
            next_q    <= '0;
            pend_q    <= 1'b0;
            buf_byte  <= 8'hFF;
            buf_valid <= 1'b0;
        end else begin
            pend_q <= mem_rd;
            if (clear) begin
                mem_rd    <= 1'b0;
                next_q    <= '0;
                buf_valid <= 1'b0;
            end else begin
                mem_rd <= req;
                if (req) begin
                    mem_addr <= next_q;
                    next_q   <= next_q + ADDR_W'(1);
                end
                if (pend_q) begin
                    buf_byte  <= mem_data;
                    buf_valid <= 1'b1;
                end else if (take) begin
                    buf_valid <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/cfg_serial_loader.sv
`timescale 1ns/1ps
// cfg_serial_loader: top of the serial configuration loader.
// Sequence: program pulse, wait for init, settle, stream bytes MSB first with
// a gap-free divided clock, then tail pulses while watching done.
// Assumes all timing parameters >= 1 and SETTLE_CYC >= 2 (first byte prefetch).
module cfg_serial_loader
    import cfg_loader_pkg::*;
#(
    parameter int ADDR_W           = 16,
    parameter int CNT_W            = 16,
    parameter int PROG_LOW_CYC     = 125,
    parameter int SETTLE_CYC       = 2500,
    parameter int INIT_TIMEOUT_CYC = 12500,
    parameter int CCLK_HALF        = 4,
    parameter int DONE_EXTRA       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  byte_count,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_data,
    output logic              prog_n,
    input  logic              init_in,
    output logic              cclk,
    output logic              din,
    input  logic              done_in,
    output logic              busy,
    output logic              success,
    output logic              error
);
    localparam int TMR_MAX = int'(umax(umax(PROG_LOW_CYC, SETTLE_CYC), INIT_TIMEOUT_CYC));
    localparam int TMR_W   = $clog2(TMR_MAX + 1);
    localparam int TAIL_W  = $clog2(DONE_EXTRA + 1);

    ld_state_e         state_q, state_d;
    logic              init_s, done_s;
    logic              tmr_load, tmr_exp;
    logic [TMR_W-1:0]  tmr_val;
    logic              cclk_en, rise_evt, fall_evt;
    logic              fetch_clear, fetch_req, fetch_take;
    logic [7:0]        nxt_byte;
    logic              nxt_valid;
    logic [7:0]        shreg_q;
    logic [2:0]        bit_idx_q;
    logic [CNT_W-1:0]  count_q, left_q;
    logic [TAIL_W-1:0] tail_q;
    logic              done_seen_q;
    logic              begin_run, load_byte, shift_bit, enter_tail;
    logic              finish_ok, finish_bad;

    cfg_sync2 #(.W(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({init_in, done_in}),
        .q     ({init_s, done_s})
    );

    cfg_delay_timer #(.W(TMR_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    cfg_cclk_gen #(.HALF(CCLK_HALF)) u_cclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (cclk_en),
        .cclk     (cclk),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );

    cfg_byte_fetch #(.ADDR_W(ADDR_W)) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (fetch_clear),
        .req       (fetch_req),
        .take      (fetch_take),
        .mem_rd    (mem_rd),
        .mem_addr  (mem_addr),
        .mem_data  (mem_data),
        .buf_byte  (nxt_byte),
        .buf_valid (nxt_valid)
    );

    // Clock runs while streaming (stops the same edge init is lost) and in the tail.
    assign cclk_en = ((state_q == ST_STREAM) && init_s) || (state_q == ST_TAIL);

    // Next-state and control decode of the sequencer.
    always_comb begin
        state_d     = state_q;
        tmr_load    = 1'b0;
        tmr_val     = '0;
        fetch_clear = 1'b0;
        fetch_req   = 1'b0;
        fetch_take  = 1'b0;
        begin_run   = 1'b0;
        load_byte   = 1'b0;
        shift_bit   = 1'b0;
        enter_tail  = 1'b0;
        finish_ok   = 1'b0;
        finish_bad  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    begin_run   = 1'b1;
                    fetch_clear = 1'b1;
                    tmr_load    = 1'b1;
                    tmr_val     = TMR_W'(PROG_LOW_CYC - 1);
                    state_d     = ST_PROG;
                end
            end
            ST_PROG: begin
                if (tmr_exp) begin
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(INIT_TIMEOUT_CYC - 1);
                    state_d  = ST_WAIT_INIT;
                end
            end
            ST_WAIT_INIT: begin
                if (init_s) begin
                    tmr_load  = 1'b1;
                    tmr_val   = TMR_W'(SETTLE_CYC - 1);
                    fetch_req = (count_q != '0);
                    state_d   = ST_SETTLE;
                end else if (tmr_exp) begin
                    finish_bad = 1'b1;
                    state_d    = ST_IDLE;
                end
            end
            ST_SETTLE: begin
                if (tmr_exp) begin
                    if (count_q == '0) begin
                        enter_tail = 1'b1;
                        state_d    = ST_TAIL;
                    end else if (nxt_valid) begin
                        load_byte  = 1'b1;
                        fetch_take = 1'b1;
                        fetch_req  = (count_q > CNT_W'(1));
                        state_d    = ST_STREAM;
                    end
                end
            end
            ST_STREAM: begin
                if (!init_s) begin
                    finish_bad = 1'b1;
                    state_d    = ST_IDLE;
                end else if (fall_evt) begin
                    if (bit_idx_q == 3'd7) begin
                        if (left_q != '0) begin
                            load_byte  = 1'b1;
                            fetch_take = 1'b1;
                            fetch_req  = (left_q > CNT_W'(1));
                        end else begin
                            enter_tail = 1'b1;
                            state_d    = ST_TAIL;
                        end
                    end else begin
                        shift_bit = 1'b1;
                    end
                end
            end
            ST_TAIL: begin
                if (fall_evt && (tail_q == TAIL_W'(DONE_EXTRA))) begin
                    if (done_seen_q || done_s) finish_ok = 1'b1;
                    else                       finish_bad = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Sequencer state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Byte shift register, bit index and remaining-byte count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q   <= 8'hFF;
            bit_idx_q <= '0;
            count_q   <= '0;
            left_q    <= '0;
        end else begin
            if (begin_run) begin
                count_q <= byte_count;
                shreg_q <= 8'hFF;
            end
            if (load_byte) begin
                shreg_q   <= nxt_byte;
                bit_idx_q <= '0;
                left_q    <= (state_q == ST_SETTLE) ? count_q - CNT_W'(1) : left_q - CNT_W'(1);
            end else if (shift_bit) begin
                shreg_q   <= {shreg_q[6:0], 1'b1};
                bit_idx_q <= bit_idx_q + 3'd1;
            end else if (enter_tail) begin
                shreg_q <= 8'hFF;
            end
        end
    end

    // Tail pulse counter and done observation.
    always_ff @(posedge clk) begin
        if (!rst_n || begin_run) begin
            tail_q      <= '0;
            done_seen_q <= 1'b0;
        end else begin
            if ((state_q == ST_TAIL) && rise_evt) tail_q <= tail_q + TAIL_W'(1);
            if (((state_q == ST_STREAM) || (state_q == ST_TAIL)) && done_s) done_seen_q <= 1'b1;
        end
    end

    // Run result flags, cleared by an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n || begin_run) begin
            success <= 1'b0;
            error   <= 1'b0;
        end else begin
            if (finish_ok)  success <= 1'b1;
            if (finish_bad) error   <= 1'b1;
        end
    end

    assign din    = shreg_q[7];
    assign prog_n = (state_q != ST_PROG);
    assign busy   = (state_q != ST_IDLE);
endmodule

// File: rtl/cfg_loader_chk.sv
`timescale 1ns/1ps
// cfg_loader_chk: protocol checker bound to the loader's ports.
module cfg_loader_chk (
    input logic clk,
    input logic rst_n,
    input logic prog_n,
    input logic cclk,
    input logic din,
    input logic mem_rd,
    input logic busy,
    input logic success,
    input logic error
);
    // R6
    din_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cclk && $past(cclk)) |-> $stable(din));

    // R11
    status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(success && error));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!cclk && prog_n && !mem_rd));

    // R2
    prog_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_n |-> (busy && !cclk));

    // R8
    end_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (success ^ error));
endmodule

bind cfg_serial_loader cfg_loader_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .prog_n  (prog_n),
    .cclk    (cclk),
    .din     (din),
    .mem_rd  (mem_rd),
    .busy    (busy),
    .success (success),
    .error   (error)
);

// File: tb/sim_cfg_serial_loader.sv
`timescale 1ns/1ps
module sim_cfg_serial_loader;
    localparam int P_LOW     = 10;
    localparam int P_SETTLE  = 40;
    localparam int P_TMO     = 200;
    localparam int P_HALF    = 3;
    localparam int P_TAIL    = 6;
    localparam real CLK_NS   = 8.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] byte_count = '0;
    logic        mem_rd;
    logic [15:0] mem_addr;
    logic [7:0]  mem_q = '0;
    logic        prog_n, cclk, din, busy, success, error;
    logic        init_in = 1'b0;
    logic        done_in = 1'b0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [7:0] mem [64];
    logic [7:0] cap [64];
    logic [7:0] shv = '0;
    int  exp_n = 0, rise_cnt = 0, cap_idx = 0, per_bad = 0, tail_bad = 0, done_at = -1;
    real last_rise = 0.0;

    always #4 clk = ~clk;

    cfg_serial_loader #(
        .PROG_LOW_CYC(P_LOW), .SETTLE_CYC(P_SETTLE), .INIT_TIMEOUT_CYC(P_TMO),
        .CCLK_HALF(P_HALF), .DONE_EXTRA(P_TAIL)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .byte_count(byte_count),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_data(mem_q),
        .prog_n(prog_n), .init_in(init_in), .cclk(cclk), .din(din),
        .done_in(done_in), .busy(busy), .success(success), .error(error)
    );

    // Byte memory with one clock of read latency.
    always @(posedge clk) if (mem_rd) mem_q <= mem[mem_addr[5:0]];

    // Device model: captures bits on cclk rise, checks period, raises done.
    always @(posedge cclk) begin
        if (rise_cnt > 0 && ($realtime - last_rise) != 2.0 * P_HALF * CLK_NS) per_bad++;
        last_rise = $realtime;
        rise_cnt++;
        shv = {shv[6:0], din};
        if (rise_cnt <= 8 * exp_n) begin
            if (rise_cnt % 8 == 0 && cap_idx < 64) begin
                cap[cap_idx] = shv;
                cap_idx++;
            end
        end else if (din !== 1'b1) begin
            tail_bad++;
        end
        if (rise_cnt == done_at) done_in = 1'b1;
    end

    function automatic int exp_rises(input int n);
        return 8 * n + P_TAIL;
    endfunction

    function automatic int exp_first_rise();
        return 3 + P_SETTLE + P_HALF;
    endfunction

    task automatic chk_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One full run: n bytes; optional init drop, done, and start poke mid-stream.
    task automatic run_load(input int n, input int init_dly, input int drop_at,
                            input bit give_done, input bit poke_start);
        int plow, w, bad;
        init_in = 1'b0; done_in = 1'b0;
        exp_n = n; rise_cnt = 0; cap_idx = 0; per_bad = 0; tail_bad = 0;
        done_at = give_done ? 8 * n + 2 : -1;
        @(negedge clk); byte_count = 16'(n); start = 1'b1;
        @(negedge clk); start = 1'b0;
        plow = 0;
        while (!prog_n && plow < 1000) begin
            if (plow == 3) start = 1'b1;   // R2: ignored while busy
            plow++;
            @(negedge clk);
            start = 1'b0;
        end
        chk_eq("R2 program low cycles", plow, P_LOW);
        repeat (init_dly) @(negedge clk);
        init_in = 1'b1;
        w = 0;
        do begin @(posedge clk); #1; w++; end while (!cclk && w < 1000);
        chk_eq("R3 init to first cclk rise", w, exp_first_rise());
        if (poke_start) begin
            while (rise_cnt < 20) @(negedge clk);
            start = 1'b1; @(negedge clk); start = 1'b0;
        end
        if (drop_at > 0) begin
            while (rise_cnt < drop_at) @(negedge clk);
            init_in = 1'b0;
        end
        while (busy) @(negedge clk);
        @(negedge clk);
        if (drop_at > 0) begin
            chk_eq("R9 error after init loss", int'(error), 1);
            chk_eq("R9 no success after init loss", int'(success), 0);
            chk_eq("R9 stream cut short", int'(rise_cnt < 8 * n), 1);
            chk_eq("R9 cclk low after abort", int'(cclk), 0);
        end else begin
            chk_eq("R7 bytes delivered", cap_idx, n);
            bad = 0;
            for (int k = 0; k < n && k < 64; k++) if (cap[k] !== mem[k]) begin
                if (bad == 0) chk_eq($sformatf("R7 byte %0d value", k), int'(cap[k]), int'(mem[k]));
                bad++;
            end
            chk_eq("R7 byte mismatches", bad, 0);
            chk_eq("R8 total cclk pulses", rise_cnt, exp_rises(n));
            chk_eq("R5 cclk period gap-free", per_bad, 0);
            chk_eq("R8 din high in tail", tail_bad, 0);
            chk_eq("R8 success", int'(success), int'(give_done));
            chk_eq("R11 error is complement", int'(error), int'(!give_done));
        end
        chk_eq("R11 busy ended", int'(busy), 0);
    endtask

    initial begin
        void'($urandom(32'd4711));
        for (int k = 0; k < 64; k++) mem[k] = 8'($urandom);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk_eq("R1 prog_n", int'(prog_n), 1);
        chk_eq("R1 cclk", int'(cclk), 0);
        chk_eq("R1 din", int'(din), 1);
        chk_eq("R1 mem_rd", int'(mem_rd), 0);
        chk_eq("R1 busy/success/error", int'({busy, success, error}), 0);

        // R7/R5: padding and sync words, plus bit-order probes 0x80 and 0x01.
        mem[0] = 8'hFF; mem[1] = 8'hFF; mem[2] = 8'h55; mem[3] = 8'h99;
        mem[4] = 8'hAA; mem[5] = 8'h66; mem[6] = 8'h80; mem[7] = 8'h01;
        run_load(10, 5, 0, 1'b1, 1'b0);

        // R8: done never rises -> error.
        run_load(3, 0, 0, 1'b0, 1'b0);

        // R10: zero count, tail only.
        run_load(0, 2, 0, 1'b1, 1'b0);
        chk_eq("R10 no data bytes", cap_idx, 0);

        // R2: start poked mid-stream is ignored.
        run_load(8, 1, 0, 1'b1, 1'b1);

        // R9: init lost during streaming.
        run_load(20, 3, 40, 1'b1, 1'b0);

        // Random lengths and contents.
        for (int r = 0; r < 4; r++) begin
            for (int k = 0; k < 64; k++) mem[k] = 8'($urandom);
            run_load(1 + int'($urandom % 24), int'($urandom % 50), 0, 1'b1, 1'b0);
        end

        // R4: init never rises.
        begin
            int bc;
            init_in = 1'b0; done_in = 1'b0; exp_n = 0; rise_cnt = 0;
            @(negedge clk); byte_count = 16'd4; start = 1'b1;
            @(negedge clk); start = 1'b0;
            bc = 0;
            while (busy && bc < 5000) begin bc++; @(negedge clk); end
            chk_eq("R4 busy length on timeout", bc, P_LOW + P_TMO);
            chk_eq("R4 timeout error", int'(error), 1);
            chk_eq("R4 no cclk on timeout", rise_cnt, 0);
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired (R11 run never ended) actual=1 expected=0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule